// File: doc/BRIEF.md
# ULPI Receive-Command Status Reporter

This block sits on the transceiver side of an 8-bit ULPI link. It watches four status sources: the two line levels of the USB pair, a two-bit encoded VBUS level, a two-bit receive-event code, and the B-session-valid flag. Whenever a reported field differs from the value last delivered, the block takes the data bus and sends one status byte (an RXCMD) to the link. It frames that byte with a turnaround cycle on the way in and another on the way out. If a field changes again while a byte is on the bus, the next byte follows on the very next cycle under the same bus ownership. Changes are never dropped.

An optional alternate interrupt flags B-session-valid edges. Two enable inputs, one for rising edges and one for falling edges, let a matching edge raise a byte with its top bit set. A role input selects how the line levels are folded into the two line-state bits, so one mapping serves peripheral use and another serves host use. While the link is driving a transmit, the block holds its request and takes the bus only once the link is idle.

Top module: `ulpi_rxcmd_reporter`

## Requirements
- R1: A status byte driven with `data_oe` high carries line state in bits 1:0, the encoded VBUS level in bits 3:2, the receive-event code in bits 5:4, a 0 in bit 6 and the alternate-interrupt flag in bit 7.
- R2: With `host_mode` low the line state is {`dm`,`dp`} (bit 1 = `dm`, bit 0 = `dp`). With `host_mode` high it is {`dp`,`dm`} (bit 1 = `dp`, bit 0 = `dm`).
- R3: A change in line state, VBUS level or event code that is sampled at clock edge k makes `dir` high after edge k. While no field differs from the last value sent, `dir` stays low.
- R4: After `dir` rises, there is one cycle with `dir` high and `data_oe` low (turnaround), then byte cycles with `data_oe` high. After the last byte, `dir` and `data_oe` are both low. `nxt` is always low.
- R5: If a field changes during a byte cycle, the next cycle carries a second byte with the newest values while `dir` stays high. Only one turnaround comes before the pair and one after it.
- R6: When `en_bv_rise` is set, a rising edge of `bvalid` sends a byte with bit 7 set. When `en_bv_fall` is set, a falling edge does the same. An edge whose enable is clear sends nothing. Bit 7 is 0 in all other bytes.
- R7: While `link_tx_active` is high and `dir` is low, `dir` stays low. A pending byte is sent once `link_tx_active` falls.
- R8: Synchronous active-low reset forces `dir` low and clears any pending request. It captures the present status as the baseline, so after reset no byte is sent until something changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | ULPI clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_mode | input | 1 | Role select for the line-state mapping (1 = host) |
| dp | input | 1 | Sampled D+ level |
| dm | input | 1 | Sampled D- level |
| vbus_enc | input | 2 | Encoded VBUS level |
| rx_event | input | 2 | Encoded receive-event code |
| bvalid | input | 1 | B-session-valid flag |
| en_bv_rise | input | 1 | Enables the alternate interrupt on a rising `bvalid` |
| en_bv_fall | input | 1 | Enables the alternate interrupt on a falling `bvalid` |
| link_tx_active | input | 1 | Link is driving a transmit; the bus is not free |
| dir | output | 1 | Bus direction, high while this block owns the bus |
| nxt | output | 1 | Next-data strobe, held low |
| data_out | output | 8 | Status byte |
| data_oe | output | 1 | Data bus drive enable |

## Verification
A table of eight status steps changes one, two or all three fields at a time, in both roles. This separates a wrong bit layout from a wrong line-state mapping and from missed per-field change detection. Directed cases then cover the remaining behaviour:
- A change that arrives during a byte cycle, to tell back-to-back sending apart from a fresh turnaround.
- A change made while the link transmits, to show that the byte is deferred.
- `bvalid` edges with each enable on and off, which expose a wrong edge polarity or a stuck bit 7.
- A reset taken with non-idle status, to show that the baseline capture keeps the block silent afterwards.

// File: rtl/ulpi_rxcmd_pkg.sv
// Package: shared types and sizes for the receive-command status reporter.
// Assumes every reported status field is FIELD_W bits wide.
package ulpi_rxcmd_pkg;
    localparam int DATA_W     = 8;
    localparam int FIELD_W    = 2;
    localparam int NUM_FIELDS = 3;
    localparam int STATUS_W   = FIELD_W * NUM_FIELDS;

    // Bus ownership phases of one receive-command burst
    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_TURN_ON  = 2'd1,
        ST_SEND     = 2'd2,
        ST_TURN_OFF = 2'd3
    } bus_state_t;

    // Packed status, lowest field at the lowest bits (byte bits 5:0)
    typedef struct packed {
        logic [FIELD_W-1:0] evt;
        logic [FIELD_W-1:0] vbus;
        logic [FIELD_W-1:0] ls;
    } status_t;
endpackage

// File: rtl/ulpi_linestate_map.sv
// Module: folds the two line levels into line-state bits based on port role.
// Peripheral role gives {dm,dp}; host role gives {dp,dm}. Purely combinational.
module ulpi_linestate_map (
    input  logic       host_mode,
    input  logic       dp,
    input  logic       dm,
    output logic [1:0] ls
);
    // Select the role-dependent bit order
    always_comb begin
        if (host_mode) ls = {dp, dm};
        else           ls = {dm, dp};
    end
endmodule

// File: rtl/ulpi_status_tracker.sv
// Module: keeps the last-sent status, detects changes per field and tracks
// enabled B-session-valid edges. Assumes inputs are already synchronous to clk.
// On reset the present status becomes the baseline so nothing is reported.
module ulpi_status_tracker
    import ulpi_rxcmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  status_t           cur,
    input  logic              bvalid,
    input  logic              en_bv_rise,
    input  logic              en_bv_fall,
    input  logic              load,
    output logic              pending,
    output logic [DATA_W-1:0] byte_next
);
    status_t                 baseline;
    logic                    bv_q;
    logic                    alt_pend;
    logic                    edge_hit;
    logic [NUM_FIELDS-1:0]   field_chg;
    logic [STATUS_W-1:0]     cur_vec;
    logic [STATUS_W-1:0]     base_vec;

    assign cur_vec  = cur;
    assign base_vec = baseline;

    // Per-field inequality against the last delivered value
    generate
        for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_field
            assign field_chg[i] = cur_vec[i*FIELD_W +: FIELD_W] != base_vec[i*FIELD_W +: FIELD_W];
        end
    endgenerate

    // Enabled edge of B-session-valid
    always_comb begin
        edge_hit = (bvalid & ~bv_q & en_bv_rise) | (~bvalid & bv_q & en_bv_fall);
    end

    // Request and the byte that would be sent now
    always_comb begin
        pending   = (|field_chg) | alt_pend;
        byte_next = {alt_pend, 1'b0, cur_vec};
    end

    // Baseline, edge history and alternate-interrupt flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            baseline <= cur;
            bv_q     <= bvalid;
            alt_pend <= 1'b0;
        end else begin
            bv_q <= bvalid;
            if (load) baseline <= cur;
            alt_pend <= edge_hit | (alt_pend & ~load);
        end
    end
endmodule

// File: rtl/ulpi_rxcmd_fsm.sv
// Module: owns the bus. Adds a turnaround on takeover and release, streams
// bytes back-to-back while requests remain, defers takeover while the link
// transmits. The byte is registered in the cycle before it is driven.
module ulpi_rxcmd_fsm
    import ulpi_rxcmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pending,
    input  logic              link_tx_active,
    input  logic [DATA_W-1:0] byte_next,
    output logic              load,
    output logic              dir,
    output logic              data_oe,
    output logic [DATA_W-1:0] data_out
);
    bus_state_t        state, state_nx;
    logic [DATA_W-1:0] data_q;

    // Next-phase decision
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:     if (pending && !link_tx_active) state_nx = ST_TURN_ON;
            ST_TURN_ON:  state_nx = ST_SEND;
            ST_SEND:     state_nx = pending ? ST_SEND : ST_TURN_OFF;
            ST_TURN_OFF: state_nx = ST_IDLE;
            default:     state_nx = ST_IDLE;
        endcase
    end

    // Capture strobe: the cycle before each byte cycle
    always_comb begin
        load = (state == ST_TURN_ON) || (state == ST_SEND && pending);
    end

    // Bus pin decode from the phase
    always_comb begin
        dir      = (state == ST_TURN_ON) || (state == ST_SEND);
        data_oe  = (state == ST_SEND);
        data_out = data_oe ? data_q : '0;
    end

    // Phase and byte registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            data_q <= '0;
        end else begin
            state <= state_nx;
            if (load) data_q <= byte_next;
        end
    end
endmodule

// File: rtl/ulpi_rxcmd_reporter.sv
// Module: top of the receive-command status reporter. Maps line levels,
// tracks status changes and drives the ULPI bus pins. Assumes all status
// inputs are sampled in the ULPI clock domain; reset is synchronous active-low.
module ulpi_rxcmd_reporter
    import ulpi_rxcmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_mode,
    input  logic              dp,
    input  logic              dm,
    input  logic [1:0]        vbus_enc,
    input  logic [1:0]        rx_event,
    input  logic              bvalid,
    input  logic              en_bv_rise,
    input  logic              en_bv_fall,
    input  logic              link_tx_active,
    output logic              dir,
    output logic              nxt,
    output logic [DATA_W-1:0] data_out,
    output logic              data_oe
);
    status_t           cur;
    logic [1:0]        ls;
    logic              pending;
    logic              load;
    logic [DATA_W-1:0] byte_next;

    ulpi_linestate_map u_map (
        .host_mode (host_mode),
        .dp        (dp),
        .dm        (dm),
        .ls        (ls)
    );

    // Assemble the live status word
    always_comb begin
        cur.ls   = ls;
        cur.vbus = vbus_enc;
        cur.evt  = rx_event;
    end

    ulpi_status_tracker u_track (
        .clk        (clk),
        .rst_n      (rst_n),
        .cur        (cur),
        .bvalid     (bvalid),
        .en_bv_rise (en_bv_rise),
        .en_bv_fall (en_bv_fall),
        .load       (load),
        .pending    (pending),
        .byte_next  (byte_next)
    );

    ulpi_rxcmd_fsm u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .pending        (pending),
        .link_tx_active (link_tx_active),
        .byte_next      (byte_next),
        .load           (load),
        .dir            (dir),
        .data_oe        (data_oe),
        .data_out       (data_out)
    );

    // Receive commands never use the next-data strobe
    assign nxt = 1'b0;
endmodule

// File: rtl/ulpi_rxcmd_checker.sv
// Module: protocol checks on the reporter's pins, attached by bind.
// Assumes the same clock and active-low reset as the reporter.
module ulpi_rxcmd_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       dir,
    input logic       data_oe,
    input logic [7:0] data_out,
    input logic       link_tx_active
);
    assert_reserved_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        data_oe |-> !data_out[6]);

    assert_turnaround_in_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dir) |-> !data_oe);

    assert_byte_after_turn_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dir) |=> data_oe);

    assert_drive_owned_R4: assert property (@(posedge clk) disable iff (!rst_n)
        data_oe |-> dir);

    assert_defer_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!dir && link_tx_active) |=> !dir);
endmodule

bind ulpi_rxcmd_reporter ulpi_rxcmd_checker u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .dir            (dir),
    .data_oe        (data_oe),
    .data_out       (data_out),
    .link_tx_active (link_tx_active)
);

// File: tb/test_ulpi_rxcmd_reporter.sv
module test_ulpi_rxcmd_reporter;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_mode = 1'b0, dp = 1'b0, dm = 1'b0;
    logic [1:0] vbus_enc = 2'd0, rx_event = 2'd0;
    logic       bvalid = 1'b0, en_bv_rise = 1'b0, en_bv_fall = 1'b0;
    logic       link_tx_active = 1'b0;
    logic       dir, nxt, data_oe;
    logic [7:0] data_out;
    int         total = 0, bad = 0, cycles = 0;

    always #4 clk = ~clk;

    ulpi_rxcmd_reporter i_ulpi_rxcmd_reporter (
        .clk(clk), .rst_n(rst_n), .host_mode(host_mode), .dp(dp), .dm(dm),
        .vbus_enc(vbus_enc), .rx_event(rx_event), .bvalid(bvalid),
        .en_bv_rise(en_bv_rise), .en_bv_fall(en_bv_fall),
        .link_tx_active(link_tx_active), .dir(dir), .nxt(nxt),
        .data_out(data_out), .data_oe(data_oe)
    );

    // Vector: {host_mode, dm, dp, vbus[1:0], evt[1:0], expected byte[7:0]}
    localparam logic [14:0] VEC [8] = '{
        {1'b0, 1'b0, 1'b1, 2'd0, 2'd0, 8'h01},
        {1'b0, 1'b1, 1'b0, 2'd2, 2'd0, 8'h0A},
        {1'b1, 1'b1, 1'b0, 2'd2, 2'd0, 8'h09},
        {1'b1, 1'b0, 1'b1, 2'd3, 2'd1, 8'h1E},
        {1'b1, 1'b1, 1'b1, 2'd3, 2'd2, 8'h2F},
        {1'b0, 1'b1, 1'b1, 2'd1, 2'd3, 8'h37},
        {1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 8'h00},
        {1'b1, 1'b0, 1'b1, 2'd0, 2'd0, 8'h02}
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Pin snapshot {dir, nxt, data_oe}
    function automatic logic [7:0] pins();
        return {5'd0, dir, nxt, data_oe};
    endfunction

    // Expect a single framed byte starting at the next edge
    task automatic expect_single(input string req, input logic [7:0] exp);
        tick();
        chk({req, " turn-on R4"}, pins(), 8'b100);
        tick();
        chk({req, " byte-cycle R4"}, pins(), 8'b101);
        chk({req, " byte R1"}, data_out, exp);
        tick();
        chk({req, " release R4"}, pins(), 8'b000);
        tick();
    endtask

    task automatic expect_quiet(input string req, input int n);
        for (int i = 0; i < n; i++) begin
            tick();
            chk(req, pins(), 8'b000);
        end
    endtask

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            bad++; total++;
            $display("FAIL watchdog actual=%0d expected<=20000", cycles);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        tick();
        chk("R8 reset dir low", pins(), 8'b000);
        rst_n = 1'b1;
        expect_quiet("R3 no change quiet", 3);

        // Table walk: R1 R2 R3 R4
        for (int v = 0; v < 8; v++) begin
            {host_mode, dm, dp, vbus_enc, rx_event} = VEC[v][14:8];
            expect_single($sformatf("R2/R3 vec%0d", v), VEC[v][7:0]);
        end

        // R5 back-to-back: ls stays 10 (host, dm0 dp1)
        vbus_enc = 2'd2;
        tick();
        chk("R5 turn-on", pins(), 8'b100);
        tick();
        chk("R5 first byte", data_out, 8'h0A);
        rx_event = 2'd1;
        tick();
        chk("R5 still owned", pins(), 8'b101);
        chk("R5 second byte", data_out, 8'h1A);
        tick();
        chk("R5 release", pins(), 8'b000);
        tick();

        // R7 deferral
        link_tx_active = 1'b1;
        vbus_enc = 2'd0;
        expect_quiet("R7 deferred", 3);
        link_tx_active = 1'b0;
        expect_single("R7 after idle", 8'h12);

        // R6 alternate interrupt: rise enabled
        en_bv_rise = 1'b1;
        bvalid = 1'b1;
        tick();
        chk("R6 edge latency", pins(), 8'b000);
        expect_single("R6 rise", 8'h92);
        // fall disabled
        bvalid = 1'b0;
        expect_quiet("R6 fall disabled", 4);
        // only fall enabled
        en_bv_rise = 1'b0;
        en_bv_fall = 1'b1;
        bvalid = 1'b1;
        expect_quiet("R6 rise disabled", 4);
        bvalid = 1'b0;
        tick();
        expect_single("R6 fall", 8'h92);
        en_bv_fall = 1'b0;
        rx_event = 2'd3;
        expect_single("R6 bit7 clear", 8'h32);

        // R8 reset with non-idle status, then change during reset
        rst_n = 1'b0;
        host_mode = 1'b0; dm = 1'b1; dp = 1'b0; vbus_enc = 2'd1; rx_event = 2'd2;
        tick();
        chk("R8 in reset", pins(), 8'b000);
        rst_n = 1'b1;
        expect_quiet("R8 baseline quiet", 5);
        dp = 1'b1;
        expect_single("R8 first change", 8'h27);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule